// File: doc/BRIEF.md
# Vectored Exception Handler Fetch Sequencer

This block takes a pipeline into an exception handler whose entry point is held in memory, not wired into the logic. A table of handler addresses sits in data memory at a base address fixed when the block is built. When the block accepts an exception request, it latches the cause code and runs a short pseudo-operation through the execute, memory and write-back steps. In the execute step it forms the entry address by scaling the cause code to the entry size and adding the table base. In the memory step it issues a single read on the data-memory port. In the write-back step it drives the returned word onto the PC-load port for one cycle.

Fetch is held from the cycle after acceptance until the PC has been loaded, so the front end carries only bubbles while the sequence runs. Further requests that arrive during a running sequence have no effect. The read port has a fixed latency, set by a parameter. The entry size, the base address and all widths are also parameters.

Top module: `exc_vector_fetch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, fetch_hold, pc_load and mem_rd_en are all low.
- R2: A request sampled high at a clock edge while busy is low is accepted, and busy is high from the cycle that follows that edge.
- R3: The entry address equals TABLE_BASE plus the cause code times ENTRY_BYTES (default 4, so the code shifted left by two bits). It appears on mem_rd_addr in the memory step, which is the second cycle after the accepting edge.
- R4: mem_rd_en is high for exactly one cycle per accepted request.
- R5: pc_value during the pc_load cycle equals the mem_rd_data word present RD_LAT cycles after the read cycle (default RD_LAT is 1).
- R6: pc_load is high for exactly one cycle, 3 + RD_LAT cycles after the accepting edge.
- R7: fetch_hold follows busy. Busy falls in the cycle right after the pc_load cycle.
- R8: A request presented while busy is high starts no sequence and issues no read.
- R9: A request held high through a sequence is accepted at the first edge at which busy is low, which is the edge that ends the first idle cycle after pc_load.
- R10: The cause code is captured at acceptance. Later changes on exc_code do not alter the address of the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 1 | Exception request |
| exc_code | input | CODE_W | Cause code of the request |
| mem_rd_en | output | 1 | Data-memory read strobe |
| mem_rd_addr | output | ADDR_W | Table entry address |
| mem_rd_data | input | DATA_W | Read data, valid RD_LAT cycles after the strobe |
| pc_load | output | 1 | One-cycle strobe that loads the PC |
| pc_value | output | ADDR_W | Handler address to load into the PC |
| fetch_hold | output | 1 | Stalls instruction fetch |
| busy | output | 1 | Sequence in progress |

## Verification
The bench targets cause codes 0 and 15, the ends of the table. A design that drops the scaling or the base would read the wrong entry and load a wrong PC. It also holds a request high through a whole sequence while changing its code, and gives mem_rd_data junk values outside the single valid cycle. A design that takes requests while busy would issue extra reads, and one that reads the live code would fetch the wrong entry. A design that samples the data a cycle early or late would load junk. Finally, it checks that a request waiting through a sequence is taken right after busy falls. A design that leaves busy high one cycle too long, or restarts too soon, breaks the R9 timing.

// File: rtl/exc_vec_pkg.sv
`timescale 1ns/1ps
package exc_vec_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_EX   = 3'd1,
      ST_MEM  = 3'd2,
      ST_RD   = 3'd3,
      ST_WB   = 3'd4
   } seq_st_e;
endpackage

// File: rtl/exc_vec_addr.sv
`timescale 1ns/1ps
// Entry address generator: base plus scaled cause code.
module exc_vec_addr #(
   parameter int                ADDR_W      = 32,
   parameter int                CODE_W      = 4,
   parameter int                ENTRY_BYTES = 4,
   parameter logic [ADDR_W-1:0] TABLE_BASE  = 'h0000_1000
) (
   input  logic [CODE_W-1:0] code,
   output logic [ADDR_W-1:0] addr
);
   localparam int SHIFT = $clog2(ENTRY_BYTES);

   generate
      if (SHIFT == 0) begin : g_byte_entries
         assign addr = TABLE_BASE + ADDR_W'(code);
      end else begin : g_wide_entries
         assign addr = TABLE_BASE + (ADDR_W'(code) << SHIFT);
      end
   endgenerate
endmodule

// File: rtl/exc_vec_lat.sv
`timescale 1ns/1ps
// Counts the fixed read latency after the read strobe.
module exc_vec_lat #(
   parameter int RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   output logic done
);
   localparam int CNT_W = $clog2(RD_LAT + 1);

   logic [CNT_W-1:0] cnt;

   assign done = active && (cnt == CNT_W'(RD_LAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (start)           cnt <= CNT_W'(1);
      else if (active && !done) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/exc_vec_ctrl.sv
`timescale 1ns/1ps
// Step sequencer: idle -> execute -> memory -> read wait -> write-back.
module exc_vec_ctrl
   import exc_vec_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req,
   input  logic    lat_done,
   output seq_st_e state,
   output logic    accept
);
   seq_st_e nxt;

   assign accept = (state == ST_IDLE) && req;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (req) nxt = ST_EX;
         ST_EX:   nxt = ST_MEM;
         ST_MEM:  nxt = ST_RD;
         ST_RD:   if (lat_done) nxt = ST_WB;
         ST_WB:   nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/exc_vector_fetch.sv
`timescale 1ns/1ps
// Vectored exception entry: fetches the handler PC from a memory table.
module exc_vector_fetch
   import exc_vec_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 32,
   parameter int                CODE_W      = 4,
   parameter int                ENTRY_BYTES = 4,
   parameter int                RD_LAT      = 1,
   parameter logic [ADDR_W-1:0] TABLE_BASE  = 'h0000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic [CODE_W-1:0] exc_code,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_value,
   output logic              fetch_hold,
   output logic              busy
);
   generate
      if (RD_LAT < 1) begin : g_bad_lat
         $error("RD_LAT must be at least 1");
      end
      if (DATA_W < ADDR_W) begin : g_bad_data_w
         $error("DATA_W must cover ADDR_W");
      end
      if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0) begin : g_bad_entry
         $error("ENTRY_BYTES must be a power of two");
      end
      if ((TABLE_BASE % ENTRY_BYTES) != 0) begin : g_bad_base
         $error("TABLE_BASE must be aligned to ENTRY_BYTES");
      end
   endgenerate

   seq_st_e           state;
   logic              accept;
   logic              lat_done;
   logic [CODE_W-1:0] code_q;
   logic [ADDR_W-1:0] addr_ex;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] pc_q;

   exc_vec_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (exc_req),
      .lat_done (lat_done),
      .state    (state),
      .accept   (accept)
   );

   exc_vec_addr #(
      .ADDR_W      (ADDR_W),
      .CODE_W      (CODE_W),
      .ENTRY_BYTES (ENTRY_BYTES),
      .TABLE_BASE  (TABLE_BASE)
   ) u_addr (
      .code (code_q),
      .addr (addr_ex)
   );

   exc_vec_lat #(.RD_LAT(RD_LAT)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (state == ST_MEM),
      .active (state == ST_RD),
      .done   (lat_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         addr_q <= '0;
         pc_q   <= '0;
      end else begin
         if (accept)                       code_q <= exc_code;
         if (state == ST_EX)               addr_q <= addr_ex;
         if ((state == ST_RD) && lat_done) pc_q   <= mem_rd_data[ADDR_W-1:0];
      end
   end

   assign busy        = (state != ST_IDLE);
   assign fetch_hold  = busy;
   assign mem_rd_en   = (state == ST_MEM);
   assign mem_rd_addr = addr_q;
   assign pc_load     = (state == ST_WB);
   assign pc_value    = pc_q;
endmodule

// File: rtl/exc_vec_chk.sv
`timescale 1ns/1ps
// Property checker, bound to the top module.
module exc_vec_chk #(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 32,
   parameter int                CODE_W      = 4,
   parameter int                ENTRY_BYTES = 4,
   parameter logic [ADDR_W-1:0] TABLE_BASE  = 'h0000_1000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_req,
   input logic [CODE_W-1:0] exc_code,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic [DATA_W-1:0] mem_rd_data,
   input logic              pc_load,
   input logic [ADDR_W-1:0] pc_value,
   input logic              fetch_hold,
   input logic              busy
);
   localparam int SHIFT = $clog2(ENTRY_BYTES);

   logic [CODE_W-1:0] code_chk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                code_chk <= '0;
      else if (exc_req && !busy) code_chk <= exc_code;
   end

   a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !busy) |=> busy);

   a_r3_entry_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (mem_rd_addr == TABLE_BASE + (ADDR_W'(code_chk) << SHIFT)));

   a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   a_r4_read_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (busy && fetch_hold));

   a_r5_pc_from_data: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (pc_value == $past(mem_rd_data[ADDR_W-1:0])));

   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> (!pc_load && !busy && !fetch_hold));

   a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pc_load) |=> busy);
endmodule

bind exc_vector_fetch exc_vec_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .CODE_W      (CODE_W),
   .ENTRY_BYTES (ENTRY_BYTES),
   .TABLE_BASE  (TABLE_BASE)
) u_chk (.*);

// File: tb/exc_vector_fetch_bench.sv
`timescale 1ns/1ps
module exc_vector_fetch_bench;
   localparam int          AW     = 32;
   localparam int          DW     = 32;
   localparam int          CW     = 4;
   localparam int          LAT    = 1;
   localparam logic [31:0] BASE   = 32'h0000_1000;
   localparam int          WB_PH  = 3 + LAT;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          exc_req;
   logic [CW-1:0] exc_code;
   logic          mem_rd_en;
   logic [AW-1:0] mem_rd_addr;
   logic [DW-1:0] mem_rd_data;
   logic          pc_load;
   logic [AW-1:0] pc_value;
   logic          fetch_hold;
   logic          busy;

   always #5 clk = ~clk;

   exc_vector_fetch #(
      .ADDR_W(AW), .DATA_W(DW), .CODE_W(CW), .ENTRY_BYTES(4),
      .RD_LAT(LAT), .TABLE_BASE(BASE)
   ) u_exc_vector_fetch (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .pc_load(pc_load), .pc_value(pc_value), .fetch_hold(fetch_hold), .busy(busy)
   );

   int          n_checks = 0;
   int          n_fail   = 0;
   int          n_reads  = 0;
   bit          done     = 1'b0;
   int          ph       = 0;
   logic [CW-1:0] code_m = '0;
   int          pend     = 0;
   bit          dvalid   = 1'b0;
   logic [31:0] paddr    = '0;

   function automatic logic [31:0] word_at(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   function automatic logic [31:0] entry_of(input logic [CW-1:0] c);
      return BASE + ({28'd0, c} << 2);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      logic          acc;
      logic [CW-1:0] c;
      acc = exc_req && (ph == 0) && rst_n;
      c   = exc_code;
      @(posedge clk);
      if (!rst_n)            ph = 0;
      else if (ph == WB_PH)  ph = 0;
      else if (ph != 0)      ph++;
      else if (acc) begin ph = 1; code_m = c; end
      #1;
      if (dvalid) begin mem_rd_data = $urandom; dvalid = 1'b0; end
      if (pend > 0) begin
         pend--;
         if (pend == 0) begin mem_rd_data = word_at(paddr); dvalid = 1'b1; end
      end
      @(negedge clk);
      if (mem_rd_en) begin pend = LAT; paddr = mem_rd_addr; n_reads++; end
      if (rst_n) begin
         chk(busy == (ph != 0), "R2 R7 R8", "busy", 32'(busy), 32'(ph != 0));
         chk(fetch_hold == (ph != 0), "R7", "fetch_hold", 32'(fetch_hold), 32'(ph != 0));
         chk(mem_rd_en == (ph == 2), "R4", "mem_rd_en", 32'(mem_rd_en), 32'(ph == 2));
         if (ph == 2)
            chk(mem_rd_addr == entry_of(code_m), "R3 R10", "mem_rd_addr",
                mem_rd_addr, entry_of(code_m));
         chk(pc_load == (ph == WB_PH), "R6", "pc_load", 32'(pc_load), 32'(ph == WB_PH));
         if (ph == WB_PH)
            chk(pc_value == word_at(entry_of(code_m)), "R5", "pc_value",
                pc_value, word_at(entry_of(code_m)));
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 200000, 0);
         finish_run();
      end
   end

   initial begin
      int r0;
      void'($urandom(32'd20240611));
      rst_n       = 1'b0;
      exc_req     = 1'b0;
      exc_code    = '0;
      mem_rd_data = 32'hDEAD_BEEF;
      repeat (3) tick();
      // R1: outputs quiet in reset
      chk({busy, fetch_hold, pc_load, mem_rd_en} == 4'b0, "R1", "reset outputs",
          {28'd0, busy, fetch_hold, pc_load, mem_rd_en}, 32'd0);
      rst_n = 1'b1;
      tick();
      chk({busy, fetch_hold, pc_load, mem_rd_en} == 4'b0, "R1", "after reset",
          {28'd0, busy, fetch_hold, pc_load, mem_rd_en}, 32'd0);

      // R3: lowest table entry
      exc_req = 1'b1; exc_code = 4'd0; tick();
      exc_req = 1'b0; repeat (8) tick();
      // R3: highest table entry
      exc_req = 1'b1; exc_code = 4'd15; tick();
      exc_req = 1'b0; exc_code = 4'd7; repeat (8) tick();

      // R8, R9, R10: request held through a sequence with changing code
      r0 = n_reads;
      exc_req = 1'b1; exc_code = 4'd3; tick();
      exc_code = 4'd9;
      for (int i = 0; i < 20 && !pc_load; i++) tick();
      tick();
      chk(busy == 1'b0, "R9", "idle cycle after pc_load", 32'(busy), 32'd0);
      tick();
      chk(busy == 1'b1, "R9", "held request re-accepted", 32'(busy), 32'd1);
      exc_req = 1'b0;
      repeat (10) tick();
      chk((n_reads - r0) == 2, "R8", "reads for held request", n_reads - r0, 32'd2);

      // random traffic
      for (int i = 0; i < 600; i++) begin
         exc_req  = (($urandom % 10) < 3);
         exc_code = CW'($urandom);
         tick();
      end
      exc_req = 1'b0;
      repeat (10) tick();
      finish_run();
   end
endmodule